// File: doc/BRIEF.md
# Audio Converter Control-Port Configuration Sequencer

This block brings an external audio converter out of reset and programs it over a four-wire serial control port. These are an active-low converter reset, an active-low chip select, a control clock and a serial data line. When system reset is released it holds the converter in reset for a set number of system clocks. It then sends a throw-away all-zero word that the converter discards, and after that the real 32-bit configuration word. When that word has gone out it raises a done flag.

The configuration word is built from plain input fields: an interrupt-pin mask, a general-purpose output bit, two 5-bit output attenuation codes in 1.5 dB steps (0 to 46.5 dB), a mute bit, two input multiplexer selects and two 4-bit input gain codes in 1.5 dB steps (0 to 22.5 dB). Once done is high, a single-cycle start request sends the current configuration one more time. This retrigger does not repeat the converter reset and does not send the dummy word.

Top module: `codec_cfg_seq`

## Requirements
- R1: After system reset is released, `codecResetN` stays low for at least RESET_CYCLES and at most RESET_CYCLES+2 system clocks. While it is low, `csN` stays high, `cclk` stays low and `done` stays low.
- R2: The first transfer after reset is a dummy word of 32 zero bits.
- R3: Every transfer sends exactly 32 bits inside a single low window of `csN`. The most significant bit goes first, so bits 31..16 are sent before bits 15..0.
- R4: `cclk` toggles only while `csN` is low. Each high phase and each low phase between bits lasts exactly HALF_CYCLES system clocks.
- R5: `cdata` changes on the same clock as the rising `cclk` and holds steady for the whole high phase.
- R6: The second transfer carries the configuration word. Bit 31 is 0, bit 30 is the interrupt mask, bit 29 is the general output, bits 28..24 are the left attenuation, bits 23..19 are the right attenuation, bit 18 is mute, bit 17 is the left input select, bit 16 is the right input select, bits 15..12 are the left gain, bits 11..8 are the right gain, and bits 7..0 are 0.
- R7: Between two transfers, `csN` stays high for at least 2*HALF_CYCLES system clocks.
- R8: `done` goes high after the second transfer ends and stays high, with `csN` high, until a start request arrives.
- R9: A start request while `done` is high clears `done` on the next clock and sends exactly one configuration word. It sends no dummy word and does not pulse `codecResetN` low again.
- R10: A start request while a transfer is in progress is ignored.
- R11: The configuration fields are captured when `csN` falls. Changing them during a transfer does not alter the word being sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous system reset |
| startReq | input | 1 | Retrigger request, acted on only when done is high |
| intMask | input | 1 | Interrupt-pin mask field |
| genOut | input | 1 | General-purpose output field |
| attnLeft | input | 5 | Left output attenuation code |
| attnRight | input | 5 | Right output attenuation code |
| muteOut | input | 1 | Output mute field |
| selLeft | input | 1 | Left input multiplexer select |
| selRight | input | 1 | Right input multiplexer select |
| gainLeft | input | 4 | Left input gain code |
| gainRight | input | 4 | Right input gain code |
| codecResetN | output | 1 | Active-low converter reset |
| csN | output | 1 | Active-low control-port chip select |
| cclk | output | 1 | Control-port serial clock |
| cdata | output | 1 | Control-port serial data |
| done | output | 1 | Configuration complete |

## Verification
The converter reset is due RESET_CYCLES clocks after release, and the bench accepts a window two clocks wide for where the release falls. Every control-clock phase is due exactly HALF_CYCLES clocks after the previous edge, and the gap between transfers is due 2*HALF_CYCLES clocks after the rise of `csN`. A monitor samples on the falling system clock, measures these phase lengths as it goes, and rebuilds each word bit by bit on the rising `cclk`. Done is due one clock after the last low phase, and its fall one clock after a start request. The scenario tasks wait on `done` with a bounded loop and then compare the captured words, bit counts and timing error counters.

// File: rtl/codec_cfg_pkg.sv
package codec_cfg_pkg;
  localparam int WORD_BITS = 32;

  typedef struct packed {
    logic loadCfg;
    logic loadZero;
    logic clkRise;
    logic clkFall;
  } seqStrobe_t;

  function automatic logic [WORD_BITS-1:0] packCfg(
    input logic       intMask,
    input logic       genOut,
    input logic [4:0] attnLeft,
    input logic [4:0] attnRight,
    input logic       muteOut,
    input logic       selLeft,
    input logic       selRight,
    input logic [3:0] gainLeft,
    input logic [3:0] gainRight
  );
    return {1'b0, intMask, genOut, attnLeft, attnRight, muteOut,
            selLeft, selRight, gainLeft, gainRight, 8'h00};
  endfunction
endpackage

// File: rtl/codec_cfg_ctrl.sv
module codec_cfg_ctrl
  import codec_cfg_pkg::*;
#(
  parameter int RESET_CYCLES = 5000000,
  parameter int HALF_CYCLES  = 4
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       startReq,
  input  logic       lastBit,
  output seqStrobe_t strobe,
  output logic       codecResetN,
  output logic       csN,
  output logic       done
);
  localparam int GAP_CYCLES = 2 * HALF_CYCLES;
  localparam int TMAX = (RESET_CYCLES > GAP_CYCLES) ? RESET_CYCLES : GAP_CYCLES;
  localparam int TW = $clog2(TMAX + 1);

  typedef enum logic [2:0] {S_RST, S_GAP, S_SETUP, S_HI, S_LO, S_IDLE} seqState_t;

  seqState_t state, nextState;
  logic [TW-1:0] timer, limit;
  logic expired, isDummy;

  always_comb begin
    case (state)
      S_RST:   limit = TW'(RESET_CYCLES - 1);
      S_GAP:   limit = TW'(GAP_CYCLES - 1);
      default: limit = TW'(HALF_CYCLES - 1);
    endcase
  end
  assign expired = (timer == limit);

  always_comb begin
    strobe    = '0;
    nextState = state;
    case (state)
      S_RST: if (expired) nextState = S_GAP;
      S_GAP: if (expired) begin
        nextState = S_SETUP;
        if (isDummy) strobe.loadZero = 1'b1;
        else         strobe.loadCfg  = 1'b1;
      end
      S_SETUP: if (expired) begin
        strobe.clkRise = 1'b1;
        nextState = S_HI;
      end
      S_HI: if (expired) begin
        strobe.clkFall = 1'b1;
        nextState = S_LO;
      end
      S_LO: if (expired) begin
        if (lastBit) nextState = isDummy ? S_GAP : S_IDLE;
        else begin
          strobe.clkRise = 1'b1;
          nextState = S_HI;
        end
      end
      S_IDLE: if (startReq) nextState = S_GAP;
      default: nextState = S_RST;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state       <= S_RST;
      timer       <= '0;
      isDummy     <= 1'b1;
      codecResetN <= 1'b0;
      csN         <= 1'b1;
      done        <= 1'b0;
    end else begin
      state <= nextState;
      if (nextState != state || state == S_IDLE) timer <= '0;
      else timer <= timer + TW'(1);
      if (state == S_LO && expired && lastBit) isDummy <= 1'b0;
      codecResetN <= (nextState != S_RST);
      csN  <= !(nextState == S_SETUP || nextState == S_HI || nextState == S_LO);
      done <= (nextState == S_IDLE);
    end
  end

  AST_RESET_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !codecResetN |-> (csN && !done)); // R1
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (csN && codecResetN)); // R8
  AST_NO_RESET_AGAIN: assert property (@(posedge clk) disable iff (!rstN)
    $past(codecResetN) |-> codecResetN); // R9
  AST_START_BUSY_IGNORED: assert property (@(posedge clk) disable iff (!rstN)
    (!csN && startReq) |=> !done); // R10
endmodule

// File: rtl/codec_cfg_shift.sv
module codec_cfg_shift
  import codec_cfg_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  seqStrobe_t           strobe,
  input  logic [WORD_BITS-1:0] cfgWord,
  output logic                 cclk,
  output logic                 cdata,
  output logic                 lastBit
);
  localparam int BW = $clog2(WORD_BITS + 1);

  logic [WORD_BITS-1:0] shiftReg;
  logic [BW-1:0]        bitCnt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shiftReg <= '0;
      bitCnt   <= '0;
      cclk     <= 1'b0;
      cdata    <= 1'b0;
    end else if (strobe.loadCfg || strobe.loadZero) begin
      shiftReg <= strobe.loadCfg ? cfgWord : '0;
      bitCnt   <= '0;
      cclk     <= 1'b0;
      cdata    <= 1'b0;
    end else if (strobe.clkRise) begin
      cdata    <= shiftReg[WORD_BITS-1];
      shiftReg <= {shiftReg[WORD_BITS-2:0], 1'b0};
      bitCnt   <= bitCnt + BW'(1);
      cclk     <= 1'b1;
    end else if (strobe.clkFall) begin
      cclk <= 1'b0;
    end
  end

  assign lastBit = (bitCnt == BW'(WORD_BITS));

  AST_DATA_HELD_HIGH: assert property (@(posedge clk) disable iff (!rstN)
    (cclk && $past(cclk)) |-> $stable(cdata)); // R5
  AST_BIT_LIMIT: assert property (@(posedge clk) disable iff (!rstN)
    bitCnt <= BW'(WORD_BITS)); // R3
  AST_SINGLE_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobe.loadCfg, strobe.loadZero, strobe.clkRise, strobe.clkFall})); // R4
endmodule

// File: rtl/codec_cfg_seq.sv
module codec_cfg_seq
  import codec_cfg_pkg::*;
#(
  parameter int RESET_CYCLES = 5000000,
  parameter int HALF_CYCLES  = 4
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       startReq,
  input  logic       intMask,
  input  logic       genOut,
  input  logic [4:0] attnLeft,
  input  logic [4:0] attnRight,
  input  logic       muteOut,
  input  logic       selLeft,
  input  logic       selRight,
  input  logic [3:0] gainLeft,
  input  logic [3:0] gainRight,
  output logic       codecResetN,
  output logic       csN,
  output logic       cclk,
  output logic       cdata,
  output logic       done
);
  seqStrobe_t           strobe;
  logic                 lastBit;
  logic [WORD_BITS-1:0] cfgWord;

  assign cfgWord = packCfg(intMask, genOut, attnLeft, attnRight, muteOut,
                           selLeft, selRight, gainLeft, gainRight);

  codec_cfg_ctrl #(.RESET_CYCLES(RESET_CYCLES), .HALF_CYCLES(HALF_CYCLES)) uCtrl (
    .clk(clk), .rstN(rstN), .startReq(startReq), .lastBit(lastBit),
    .strobe(strobe), .codecResetN(codecResetN), .csN(csN), .done(done)
  );

  codec_cfg_shift uShift (
    .clk(clk), .rstN(rstN), .strobe(strobe), .cfgWord(cfgWord),
    .cclk(cclk), .cdata(cdata), .lastBit(lastBit)
  );

  AST_CLK_UNDER_SELECT: assert property (@(posedge clk) disable iff (!rstN)
    cclk |-> !csN); // R4
endmodule

// File: tb/sim_codec_cfg_seq.sv
module sim_codec_cfg_seq;
  localparam int RST_C = 200;
  localparam int HALF_C = 4;

  logic clk = 1'b0, rstN = 1'b0, startReq = 1'b0;
  logic intMask = 0, genOut = 0, muteOut = 0, selLeft = 0, selRight = 0;
  logic [4:0] attnLeft = 0, attnRight = 0;
  logic [3:0] gainLeft = 0, gainRight = 0;
  logic codecResetN, csN, cclk, cdata, done;

  always #5 clk = ~clk;

  codec_cfg_seq #(.RESET_CYCLES(RST_C), .HALF_CYCLES(HALF_C)) u0 (
    .clk(clk), .rstN(rstN), .startReq(startReq), .intMask(intMask), .genOut(genOut),
    .attnLeft(attnLeft), .attnRight(attnRight), .muteOut(muteOut), .selLeft(selLeft),
    .selRight(selRight), .gainLeft(gainLeft), .gainRight(gainRight),
    .codecResetN(codecResetN), .csN(csN), .cclk(cclk), .cdata(cdata), .done(done));

  int checks = 0, failures = 0;

  // monitor state
  logic [31:0] words [16];
  int bitsIn [16];
  int nWords = 0, rstLowRun = 0, rstLowLen = 0, resetFalls = 0;
  int csHighRun = 0, minGap = 1000000, highRun = 0, lowRun = 0, bitCnt = 0;
  int phaseErr = 0, stableErr = 0, csViolation = 0;
  logic [31:0] shiftWord = 0;
  logic prevCs = 1, prevCclk = 0, prevData = 0, prevRst = 0;

  always @(negedge clk) begin
    if (!rstN) begin
      prevCs = 1; prevCclk = 0; prevRst = 0; rstLowRun = 0;
    end else begin
      if (!codecResetN) rstLowRun++;
      if (codecResetN && !prevRst) rstLowLen = rstLowRun;
      if (!codecResetN && prevRst) resetFalls++;
      if (cclk && csN) csViolation++;
      if (cclk && prevCclk && cdata != prevData) stableErr++;
      if (!csN && prevCs) begin
        if (nWords > 0 && csHighRun < minGap) minGap = csHighRun;
        shiftWord = 0; bitCnt = 0; lowRun = 0; highRun = 0;
      end
      if (csN) csHighRun++;
      if (cclk && !prevCclk) begin
        if (bitCnt > 0 && lowRun != HALF_C) phaseErr++;
        shiftWord = {shiftWord[30:0], cdata};
        bitCnt++; lowRun = 0;
      end
      if (!cclk && prevCclk) begin
        if (highRun != HALF_C) phaseErr++;
        highRun = 0;
      end
      if (cclk) highRun++;
      else if (!csN) lowRun++;
      if (csN && !prevCs) begin
        if (nWords < 16) begin words[nWords] = shiftWord; bitsIn[nWords] = bitCnt; end
        nWords++; csHighRun = 1;
      end
      prevCs = csN; prevCclk = cclk; prevData = cdata; prevRst = codecResetN;
    end
  end

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk); #1;
  endtask

  task automatic setCfg(input logic im, input logic go, input logic [4:0] al, input logic [4:0] ar,
                        input logic mu, input logic sl, input logic sr,
                        input logic [3:0] gl, input logic [3:0] gr);
    intMask = im; genOut = go; attnLeft = al; attnRight = ar; muteOut = mu;
    selLeft = sl; selRight = sr; gainLeft = gl; gainRight = gr;
  endtask

  function automatic logic [31:0] expWord(input logic im, input logic go, input logic [4:0] al,
      input logic [4:0] ar, input logic mu, input logic sl, input logic sr,
      input logic [3:0] gl, input logic [3:0] gr);
    logic [31:0] w;
    w = (32'(im) << 30) | (32'(go) << 29) | (32'(al) << 24) | (32'(ar) << 19) |
        (32'(mu) << 18) | (32'(sl) << 17) | (32'(sr) << 16) | (32'(gl) << 12) | (32'(gr) << 8);
    return w;
  endfunction

  task automatic waitDone();
    for (int i = 0; i < 6000 && !done; i++) tick();
  endtask

  task automatic pulseStart();
    @(posedge clk); #1 startReq = 1'b1;
    @(posedge clk); #1 startReq = 1'b0;
  endtask

  task automatic test_reset();
    setCfg(1, 0, 5'h12, 5'h05, 1, 0, 1, 4'hA, 4'h3);
    repeat (4) tick();
    check(codecResetN == 0 && csN == 1 && cclk == 0 && done == 0, "R1 reset outputs",
          {codecResetN, csN, cclk, done}, 4'b0100);
    @(posedge clk); #3 rstN = 1'b1;
    repeat (RST_C / 2) tick();
    check(codecResetN == 0 && csN == 1 && done == 0, "R1 hold mid-reset",
          {codecResetN, csN, done}, 3'b010);
  endtask

  task automatic test_init();
    logic [31:0] e;
    e = expWord(1, 0, 5'h12, 5'h05, 1, 0, 1, 4'hA, 4'h3);
    waitDone();
    check(rstLowLen >= RST_C && rstLowLen <= RST_C + 2, "R1 reset length", rstLowLen, RST_C);
    check(done == 1 && csN == 1, "R8 done after init", {done, csN}, 2'b11);
    check(nWords == 2, "R8 two transfers", nWords, 2);
    check(words[0] == 32'h0, "R2 dummy word", words[0], 0);
    check(bitsIn[0] == 32 && bitsIn[1] == 32, "R3 bits per transfer", bitsIn[0] * 100 + bitsIn[1], 3232);
    check(words[1] == e, "R6 config word", words[1], e);
    check(minGap >= 2 * HALF_C, "R7 select gap", minGap, 2 * HALF_C);
    repeat (50) tick();
    check(done == 1 && nWords == 2, "R8 done holds", {done, 8'(nWords)}, {1'b1, 8'd2});
  endtask

  task automatic test_retrigger();
    logic [31:0] e;
    setCfg(0, 1, 5'h0B, 5'h1C, 0, 1, 0, 4'h5, 4'hC);
    e = expWord(0, 1, 5'h0B, 5'h1C, 0, 1, 0, 4'h5, 4'hC);
    pulseStart();
    tick();
    check(done == 0, "R9 done clears", done, 0);
    for (int i = 0; i < 100 && csN; i++) tick();
    repeat (20) tick();
    setCfg(1, 1, 5'h1F, 5'h00, 1, 0, 1, 4'h0, 4'hF);   // R11 change mid-transfer
    pulseStart();                                      // R10 ignored
    waitDone();
    check(nWords == 3, "R9 one more transfer", nWords, 3);
    check(words[2] == e, "R11 word captured at start", words[2], e);
    check(bitsIn[2] == 32, "R3 retrigger bit count", bitsIn[2], 32);
    check(resetFalls == 0, "R9 no reset repeat", resetFalls, 0);
    repeat (600) tick();
    check(nWords == 3 && done == 1, "R10 busy start ignored", nWords, 3);
  endtask

  task automatic test_corners();
    logic [31:0] e;
    setCfg(1, 1, 5'h1F, 5'h1F, 1, 1, 1, 4'hF, 4'hF);
    e = expWord(1, 1, 5'h1F, 5'h1F, 1, 1, 1, 4'hF, 4'hF);
    pulseStart();
    waitDone();
    check(words[3] == e && e == 32'h7FFFFF00, "R6 all-ones fields", words[3], 32'h7FFFFF00);
    check(phaseErr == 0, "R4 clock phase length", phaseErr, 0);
    check(csViolation == 0, "R4 clock under select", csViolation, 0);
    check(stableErr == 0, "R5 data stable while high", stableErr, 0);
    check(minGap >= 2 * HALF_C, "R7 gap before retrigger", minGap, 2 * HALF_C);
  endtask

  initial begin
    fork
      begin
        test_reset();
        test_init();
        test_retrigger();
        test_corners();
      end
      begin
        repeat (150000) @(posedge clk);
        failures++;
        checks++;
        $display("FAIL watchdog R8 actual=timeout expected=done");
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule